// File: doc/BRIEF.md
# Predicate-Writing Integer Compare Unit

This block evaluates one integer compare per clock cycle. It compares two 64-bit operands under one of ten relations and writes the one-bit outcome into a pair of entries in a 64-entry predicate register file that the block owns. A compare-type code decides how that outcome reaches the two target entries. The normal type writes the outcome to one entry and its inverse to the other. The unconditional type clears both entries when the guard is false. Four parallel types write only for one outcome, so that chains of AND-style or OR-style compares can fold into one predicate.

The first operand is the register input, the sign-extended 8-bit immediate, or a hard zero, selected by an operand-form input. Each compare is guarded by a predicate that the block reads from its own file. Entry 0 of the file always reads as 1. A combinational fault output flags an illegal operation in the same cycle, and a flagged compare writes nothing. A separate read port shows the contents of any entry.

Top module: `predCmpUnit`

## Requirements
- R1: `relSel` selects the relation, with first operand X and second operand `regB`: 0 equal, 1 not-equal, 2 signed X<B, 3 signed X<=B, 4 signed X>B, 5 signed X>=B, 6 unsigned X<B, 7 unsigned X<=B, 8 unsigned X>B, 9 unsigned X>=B. The outcome is 1 when the relation holds.
- R2: `opForm` selects X: 0 is `regA`, 1 is `imm8` sign-extended to 64 bits, 2 is zero. Code 3 raises the fault.
- R3: Type 0 (normal) with a true guard writes the outcome to `dstA` and its inverse to `dstB`. With a false guard both targets are left unchanged.
- R4: Type 1 (unconditional) with a false guard writes 0 to both targets. With a true guard it acts as the normal type.
- R5: Type 2 (AND) writes 0 to both targets when the outcome is 0. Type 3 (OR) writes 1 to both targets when the outcome is 1. For the other outcome both targets are unchanged.
- R6: Type 4 writes 1 to `dstA` and 0 to `dstB` when the outcome is 1. Type 5 writes 0 to `dstA` and 1 to `dstB` when the outcome is 0. For the other outcome both targets are unchanged.
- R7: A parallel type (2 to 5) with a false guard leaves both targets unchanged.
- R8: A parallel type raises the fault when used with an unsigned relation (6 to 9), or with a signed inequality (2 to 5) while `opForm` is not 2.
- R9: When `dstA` equals `dstB`, the fault is raised if the guard is true or the type is 1.
- R10: A compare that raises the fault changes no predicate entry.
- R11: Entry 0 always reads as 1, and writes aimed at it are dropped.
- R12: Writes take effect at the rising clock edge after the compare is presented. Reset clears entries 1 to 63 to 0.
- R13: A type code of 6 or 7, or a relation code of 10 to 15, raises the fault whenever `valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | A compare is presented this cycle |
| cmpType | input | 3 | Compare-type code |
| relSel | input | 4 | Relation code |
| opForm | input | 2 | First-operand source |
| regA | input | 64 | Register first operand |
| regB | input | 64 | Second operand |
| imm8 | input | 8 | Immediate first operand |
| guardIdx | input | 6 | Index of the guarding predicate |
| dstA | input | 6 | First target index |
| dstB | input | 6 | Second target index |
| rdIdx | input | 6 | Read-port index |
| rdVal | output | 1 | Predicate value at `rdIdx` |
| illegalOp | output | 1 | Illegal-operation fault for the current compare |

## Verification
The hardest cases to reach are the ones where a compare that writes nothing must still leave the file exactly as it was: a parallel compare whose outcome is the inactive one, a faulting compare whose targets already hold known values, and an unconditional compare whose guard has been made false by earlier compares. The stimulus first sets targets and guards to known values with normal compares. It then issues the compare under test and reads each affected entry back through the read port. After the directed cases, a long pseudo-random run over a small index range forces target collisions, false guards and illegal combinations together. Every cycle of that run reads one entry and checks it against a bench-side model of the file.

// File: rtl/predCmpPkg.sv
package predCmpPkg;

  typedef enum logic [2:0] {
    CT_NORMAL  = 3'd0,
    CT_UNC     = 3'd1,
    CT_AND     = 3'd2,
    CT_OR      = 3'd3,
    CT_ORANDCM = 3'd4,
    CT_ANDORCM = 3'd5
  } cmpType_e;

  typedef enum logic [3:0] {
    REL_EQ  = 4'd0,
    REL_NE  = 4'd1,
    REL_LT  = 4'd2,
    REL_LE  = 4'd3,
    REL_GT  = 4'd4,
    REL_GE  = 4'd5,
    REL_LTU = 4'd6,
    REL_LEU = 4'd7,
    REL_GTU = 4'd8,
    REL_GEU = 4'd9
  } rel_e;

  typedef enum logic [1:0] {
    FORM_REG  = 2'd0,
    FORM_IMM  = 2'd1,
    FORM_ZERO = 2'd2
  } form_e;

  localparam int unsigned LAST_TYPE = 5;
  localparam int unsigned LAST_REL  = 9;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic valA;
    logic valB;
  } predWrStrobe_t;

endpackage

// File: rtl/predCmpComparator.sv
module predCmpComparator
  import predCmpPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opX,
  input  logic [DATA_W-1:0] opY,
  input  logic [3:0]        relSel,
  output logic              result
);

  logic isEq;
  logic sLess;
  logic uLess;

  always_comb begin
    isEq  = (opX == opY);
    sLess = ($signed(opX) < $signed(opY));
    uLess = (opX < opY);
  end

  always_comb begin
    case (relSel)
      REL_EQ:  result = isEq;
      REL_NE:  result = ~isEq;
      REL_LT:  result = sLess;
      REL_LE:  result = sLess | isEq;
      REL_GT:  result = ~(sLess | isEq);
      REL_GE:  result = ~sLess;
      REL_LTU: result = uLess;
      REL_LEU: result = uLess | isEq;
      REL_GTU: result = ~(uLess | isEq);
      REL_GEU: result = ~uLess;
      default: result = 1'b0;
    endcase
  end

endmodule

// File: rtl/predRegFile.sv
module predRegFile
  import predCmpPkg::*;
#(
  parameter int NUM_PRED = 64,
  parameter int IDX_W    = $clog2(NUM_PRED)
) (
  input  logic             clk,
  input  logic             rstN,
  input  predWrStrobe_t    strobe,
  input  logic [IDX_W-1:0] dstA,
  input  logic [IDX_W-1:0] dstB,
  input  logic [IDX_W-1:0] guardIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             guardVal,
  output logic             rdVal
);

  logic [NUM_PRED-1:0] predBits;

  generate
    for (genvar i = 0; i < NUM_PRED; i++) begin : gEntry
      if (i == 0) begin : gHard
        assign predBits[i] = 1'b1;
      end else begin : gStore
        logic hitA;
        logic hitB;
        assign hitA = strobe.wrA && (dstA == IDX_W'(i));
        assign hitB = strobe.wrB && (dstB == IDX_W'(i));
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            predBits[i] <= 1'b0;
          end else if (hitA) begin
            predBits[i] <= strobe.valA;
          end else if (hitB) begin
            predBits[i] <= strobe.valB;
          end
        end
      end
    end
  endgenerate

  assign guardVal = predBits[guardIdx];
  assign rdVal    = predBits[rdIdx];

endmodule

// File: rtl/predCmpDatapath.sv
module predCmpDatapath
  import predCmpPkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int IMM_W    = 8,
  parameter int NUM_PRED = 64,
  parameter int IDX_W    = $clog2(NUM_PRED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opForm,
  input  logic [3:0]        relSel,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [IMM_W-1:0]  imm8,
  input  logic [IDX_W-1:0]  guardIdx,
  input  logic [IDX_W-1:0]  dstA,
  input  logic [IDX_W-1:0]  dstB,
  input  logic [IDX_W-1:0]  rdIdx,
  input  predWrStrobe_t     strobe,
  output logic              cmpResult,
  output logic              guardVal,
  output logic              rdVal
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] opX;

  assign immExt = {{EXT_W{imm8[IMM_W-1]}}, imm8};

  always_comb begin
    case (opForm)
      FORM_REG: opX = regA;
      FORM_IMM: opX = immExt;
      default:  opX = '0;
    endcase
  end

  predCmpComparator #(.DATA_W(DATA_W)) uCmp (
    .opX    (opX),
    .opY    (regB),
    .relSel (relSel),
    .result (cmpResult)
  );

  predRegFile #(.NUM_PRED(NUM_PRED), .IDX_W(IDX_W)) uFile (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dstA     (dstA),
    .dstB     (dstB),
    .guardIdx (guardIdx),
    .rdIdx    (rdIdx),
    .guardVal (guardVal),
    .rdVal    (rdVal)
  );

endmodule

// File: rtl/predCmpCtrl.sv
module predCmpCtrl
  import predCmpPkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             valid,
  input  logic [2:0]       cmpType,
  input  logic [3:0]       relSel,
  input  logic [1:0]       opForm,
  input  logic [IDX_W-1:0] dstA,
  input  logic [IDX_W-1:0] dstB,
  input  logic             guardVal,
  input  logic             cmpResult,
  output predWrStrobe_t    strobe,
  output logic             illegalOp
);

  logic typeLegal;
  logic relLegal;
  logic formLegal;
  logic isParallel;
  logic isUnsigned;
  logic isIneq;
  logic parallelBad;
  logic sameDst;
  logic sameFault;

  always_comb begin
    typeLegal   = (32'(cmpType) <= LAST_TYPE);
    relLegal    = (32'(relSel) <= LAST_REL);
    formLegal   = (opForm != 2'd3);
    isParallel  = (cmpType >= CT_AND) && (cmpType <= CT_ANDORCM);
    isUnsigned  = (relSel >= REL_LTU) && (relSel <= REL_GEU);
    isIneq      = (relSel >= REL_LT) && (relSel <= REL_GE);
    parallelBad = isParallel && (isUnsigned || (isIneq && (opForm != FORM_ZERO)));
    sameDst     = (dstA == dstB);
    sameFault   = sameDst && (guardVal || (cmpType == CT_UNC));
    illegalOp   = valid && (!typeLegal || !relLegal || !formLegal || parallelBad || sameFault);
  end

  always_comb begin
    strobe = '0;
    if (valid && !illegalOp) begin
      case (cmpType)
        CT_NORMAL: begin
          strobe.wrA  = guardVal;
          strobe.wrB  = guardVal;
          strobe.valA = cmpResult;
          strobe.valB = ~cmpResult;
        end
        CT_UNC: begin
          strobe.wrA  = 1'b1;
          strobe.wrB  = 1'b1;
          strobe.valA = guardVal & cmpResult;
          strobe.valB = guardVal & ~cmpResult;
        end
        CT_AND: begin
          strobe.wrA  = guardVal & ~cmpResult;
          strobe.wrB  = guardVal & ~cmpResult;
        end
        CT_OR: begin
          strobe.wrA  = guardVal & cmpResult;
          strobe.wrB  = guardVal & cmpResult;
          strobe.valA = 1'b1;
          strobe.valB = 1'b1;
        end
        CT_ORANDCM: begin
          strobe.wrA  = guardVal & cmpResult;
          strobe.wrB  = guardVal & cmpResult;
          strobe.valA = 1'b1;
        end
        CT_ANDORCM: begin
          strobe.wrA  = guardVal & ~cmpResult;
          strobe.wrB  = guardVal & ~cmpResult;
          strobe.valB = 1'b1;
        end
        default: strobe = '0;
      endcase
    end
  end

endmodule

// File: rtl/predCmpUnit.sv
module predCmpUnit
  import predCmpPkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int IMM_W    = 8,
  parameter int NUM_PRED = 64,
  parameter int IDX_W    = $clog2(NUM_PRED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [2:0]        cmpType,
  input  logic [3:0]        relSel,
  input  logic [1:0]        opForm,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [IMM_W-1:0]  imm8,
  input  logic [IDX_W-1:0]  guardIdx,
  input  logic [IDX_W-1:0]  dstA,
  input  logic [IDX_W-1:0]  dstB,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdVal,
  output logic              illegalOp
);

  predWrStrobe_t strobe;
  logic          cmpResult;
  logic          guardVal;

  predCmpCtrl #(.IDX_W(IDX_W)) uCtrl (
    .valid     (valid),
    .cmpType   (cmpType),
    .relSel    (relSel),
    .opForm    (opForm),
    .dstA      (dstA),
    .dstB      (dstB),
    .guardVal  (guardVal),
    .cmpResult (cmpResult),
    .strobe    (strobe),
    .illegalOp (illegalOp)
  );

  predCmpDatapath #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .NUM_PRED(NUM_PRED), .IDX_W(IDX_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .opForm    (opForm),
    .relSel    (relSel),
    .regA      (regA),
    .regB      (regB),
    .imm8      (imm8),
    .guardIdx  (guardIdx),
    .dstA      (dstA),
    .dstB      (dstB),
    .rdIdx     (rdIdx),
    .strobe    (strobe),
    .cmpResult (cmpResult),
    .guardVal  (guardVal),
    .rdVal     (rdVal)
  );

endmodule

// File: rtl/predCmpChecker.sv
module predCmpChecker #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             valid,
  input logic [2:0]       cmpType,
  input logic [3:0]       relSel,
  input logic [IDX_W-1:0] dstA,
  input logic [IDX_W-1:0] dstB,
  input logic [IDX_W-1:0] rdIdx,
  input logic             rdVal,
  input logic             illegalOp,
  input logic             guardVal
);

  assert_entry0_true_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx == '0) |-> rdVal);

  assert_fault_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (valid && illegalOp) ##1 $stable(rdIdx) |-> $stable(rdVal));

  assert_normal_false_guard_R3: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !illegalOp && !guardVal && (cmpType == 3'd0)) ##1 $stable(rdIdx) |-> $stable(rdVal));

  assert_parallel_false_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !illegalOp && !guardVal && (cmpType >= 3'd2) && (cmpType <= 3'd5))
      ##1 $stable(rdIdx) |-> $stable(rdVal));

  assert_unc_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !illegalOp && !guardVal && (cmpType == 3'd1))
      ##1 ((rdIdx == $past(dstA)) && ($past(dstA) != '0)) |-> !rdVal);

  assert_same_dst_unc_R9: assert property (@(posedge clk) disable iff (!rstN)
    (valid && (cmpType == 3'd1) && (dstA == dstB)) |-> illegalOp);

  assert_parallel_unsigned_R8: assert property (@(posedge clk) disable iff (!rstN)
    (valid && (cmpType >= 3'd2) && (cmpType <= 3'd5) && (relSel >= 4'd6) && (relSel <= 4'd9))
      |-> illegalOp);

  assert_bad_code_R13: assert property (@(posedge clk) disable iff (!rstN)
    (valid && ((cmpType > 3'd5) || (relSel > 4'd9))) |-> illegalOp);

endmodule

bind predCmpUnit predCmpChecker #(.IDX_W(IDX_W)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .valid     (valid),
  .cmpType   (cmpType),
  .relSel    (relSel),
  .dstA      (dstA),
  .dstB      (dstB),
  .rdIdx     (rdIdx),
  .rdVal     (rdVal),
  .illegalOp (illegalOp),
  .guardVal  (guardVal)
);

// File: tb/tb_predCmpUnit.sv
module tb_predCmpUnit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  cmpType = '0;
  logic [3:0]  relSel = '0;
  logic [1:0]  opForm = '0;
  logic [63:0] regA = '0;
  logic [63:0] regB = '0;
  logic [7:0]  imm8 = '0;
  logic [5:0]  guardIdx = '0;
  logic [5:0]  dstA = '0;
  logic [5:0]  dstB = '0;
  logic [5:0]  rdIdx = '0;
  logic        rdVal;
  logic        illegalOp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit    isRead;
    bit    exp;
    string tag;
  } item_t;

  item_t sbQ[$];
  bit    model[64];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  predCmpUnit dut (
    .clk(clk), .rstN(rstN), .valid(valid), .cmpType(cmpType), .relSel(relSel),
    .opForm(opForm), .regA(regA), .regB(regB), .imm8(imm8), .guardIdx(guardIdx),
    .dstA(dstA), .dstB(dstB), .rdIdx(rdIdx), .rdVal(rdVal), .illegalOp(illegalOp)
  );

  function automatic bit relHolds(int r, logic [63:0] x, logic [63:0] y);
    logic signed [63:0] sx = x;
    logic signed [63:0] sy = y;
    case (r)
      0: return x == y;
      1: return x != y;
      2: return sx < sy;
      3: return sx <= sy;
      4: return sx > sy;
      5: return sx >= sy;
      6: return x < y;
      7: return x <= y;
      8: return x > y;
      9: return x >= y;
      default: return 0;
    endcase
  endfunction

  function automatic bit faultExp(int t, int r, int f, int a, int b, bit g);
    bit par = (t >= 2) && (t <= 5);
    if (t > 5 || r > 9 || f == 3) return 1;
    if (par && r >= 6) return 1;
    if (par && r >= 2 && r <= 5 && f != 2) return 1;
    if (a == b && (g || t == 1)) return 1;
    return 0;
  endfunction

  function automatic void put(int idx, bit v);
    if (idx != 0) model[idx] = v;
  endfunction

  // Driver: applies one compare, queues expected fault and read value, updates model
  task automatic doCmp(int t, int r, int f, logic [63:0] a64, logic [63:0] b64,
                       logic [7:0] im, int g, int a, int b, int rd, string tag);
    bit gv, res, flt;
    logic [63:0] x;
    @(negedge clk);
    valid = 1; cmpType = 3'(t); relSel = 4'(r); opForm = 2'(f);
    regA = a64; regB = b64; imm8 = im;
    guardIdx = 6'(g); dstA = 6'(a); dstB = 6'(b); rdIdx = 6'(rd);
    gv  = model[g];
    x   = (f == 0) ? a64 : (f == 1) ? {{56{im[7]}}, im} : 64'd0;
    res = relHolds(r, x, b64);
    flt = faultExp(t, r, f, a, b, gv);
    sbQ.push_back('{0, flt, tag});
    sbQ.push_back('{1, model[rd], tag});
    if (!flt) begin
      case (t)
        0: if (gv) begin put(a, res); put(b, !res); end
        1: begin put(a, gv && res); put(b, gv && !res); end
        2: if (gv && !res) begin put(a, 0); put(b, 0); end
        3: if (gv && res) begin put(a, 1); put(b, 1); end
        4: if (gv && res) begin put(a, 1); put(b, 0); end
        5: if (gv && !res) begin put(a, 0); put(b, 1); end
        default: ;
      endcase
    end
  endtask

  task automatic readP(int rd, string tag);
    @(negedge clk);
    valid = 0; rdIdx = 6'(rd);
    sbQ.push_back('{1, model[rd], tag});
    sbQ.push_back('{0, 1'b0, tag});
  endtask

  // Monitor: pops expected items and compares with outputs before the next edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    while (sbQ.size() > 0) begin
      item_t it;
      bit act;
      it  = sbQ.pop_front();
      act = it.isRead ? rdVal : illegalOp;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s actual=%0b expected=%0b", it.tag,
                 it.isRead ? "rdVal" : "illegalOp", act, it.exp);
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = (i == 0);
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12 reset state, R11 entry 0
    readP(0, "R11 entry0");
    readP(1, "R12 reset p1");
    readP(63, "R12 reset p63");
    // R1 R3 normal equal
    doCmp(0, 0, 0, 64'd7, 64'd7, 8'd0, 0, 1, 2, 1, "R3 normal eq");
    readP(1, "R12 R3 p1 after edge");
    readP(2, "R3 p2 complement");
    // R1 signed vs unsigned
    doCmp(0, 2, 0, '1, 64'd1, 8'd0, 0, 3, 4, 0, "R1 lt signed");
    doCmp(0, 6, 0, '1, 64'd1, 8'd0, 0, 5, 6, 0, "R1 ltu");
    readP(3, "R1 signed lt p3"); readP(5, "R1 unsigned lt p5"); readP(6, "R1 ltu p6");
    // R2 immediate and zero forms
    doCmp(0, 0, 1, 64'd0, '1, 8'hFF, 0, 7, 8, 0, "R2 imm sext");
    doCmp(0, 4, 2, 64'd99, 64'd5, 8'd0, 0, 9, 10, 0, "R2 zero form");
    readP(7, "R2 imm p7"); readP(9, "R2 zero p9"); readP(10, "R2 zero p10");
    // R3 false guard (p4 is 0)
    doCmp(0, 1, 0, 64'd1, 64'd1, 8'd0, 4, 1, 2, 0, "R3 false guard");
    readP(1, "R3 p1 held"); readP(2, "R3 p2 held");
    // R4 unconditional with false guard, then true guard
    doCmp(1, 0, 0, 64'd1, 64'd1, 8'd0, 4, 1, 7, 0, "R4 unc false guard");
    readP(1, "R4 p1 cleared"); readP(7, "R4 p7 cleared");
    doCmp(1, 1, 0, 64'd1, 64'd2, 8'd0, 0, 1, 7, 0, "R4 unc true guard");
    readP(1, "R4 p1 result"); readP(7, "R4 p7 complement");
    // R5 OR then AND
    doCmp(3, 0, 0, 64'd4, 64'd4, 8'd0, 0, 11, 12, 0, "R5 or true");
    readP(11, "R5 or p11"); readP(12, "R5 or p12");
    doCmp(2, 0, 0, 64'd4, 64'd4, 8'd0, 0, 11, 12, 0, "R5 and true no write");
    readP(11, "R5 and held p11");
    doCmp(2, 1, 0, 64'd4, 64'd4, 8'd0, 0, 11, 12, 0, "R5 and false");
    readP(11, "R5 and p11"); readP(12, "R5 and p12");
    // R6
    doCmp(4, 4, 2, 64'd0, '1, 8'd0, 0, 13, 14, 0, "R6 orandcm");
    readP(13, "R6 orandcm p13"); readP(14, "R6 orandcm p14");
    doCmp(5, 2, 2, 64'd0, '1, 8'd0, 0, 15, 16, 0, "R6 andorcm");
    readP(15, "R6 andorcm p15"); readP(16, "R6 andorcm p16");
    // R7 parallel false guard
    doCmp(3, 0, 0, 64'd1, 64'd1, 8'd0, 12, 17, 18, 0, "R7 or false guard");
    readP(17, "R7 p17 held");
    // R8 restrictions
    doCmp(3, 6, 2, 64'd0, 64'd3, 8'd0, 0, 19, 20, 0, "R8 parallel unsigned");
    doCmp(3, 2, 0, 64'd0, 64'd3, 8'd0, 0, 19, 20, 0, "R8 parallel ineq reg form");
    doCmp(3, 2, 2, 64'd0, 64'd3, 8'd0, 0, 19, 20, 0, "R8 parallel ineq zero ok");
    readP(19, "R8 p19 written");
    // R9 R10 same target
    doCmp(0, 0, 0, 64'd1, 64'd1, 8'd0, 0, 13, 13, 0, "R9 same dst true guard");
    readP(13, "R10 p13 held");
    doCmp(0, 1, 0, 64'd1, 64'd1, 8'd0, 4, 13, 13, 0, "R9 same dst false guard");
    doCmp(1, 0, 0, 64'd1, 64'd1, 8'd0, 4, 13, 13, 0, "R9 unc same dst");
    readP(13, "R10 p13 held unc");
    // R11 write to entry 0
    doCmp(0, 1, 0, 64'd1, 64'd1, 8'd0, 0, 0, 21, 0, "R11 write p0");
    readP(0, "R11 p0 still one"); readP(21, "R11 p21");
    // R13 bad codes, R2 bad form
    doCmp(6, 0, 0, 64'd1, 64'd1, 8'd0, 0, 22, 23, 0, "R13 type 6");
    doCmp(0, 12, 0, 64'd1, 64'd1, 8'd0, 0, 22, 23, 0, "R13 rel 12");
    doCmp(0, 0, 3, 64'd1, 64'd1, 8'd0, 0, 22, 23, 0, "R2 form 3");
    readP(22, "R10 p22 held");
    // Mixed pseudo-random run, small index range for collisions
    for (int n = 0; n < 600; n++) begin
      logic [63:0] va, vb;
      int t, r, f;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      t  = (lfsr[2:0] == 3'd7) ? 7 : int'(lfsr[2:0]) % 6;
      r  = (lfsr[7:4] > 4'd11) ? int'(lfsr[7:4]) : int'(lfsr[7:4]) % 10;
      f  = int'(lfsr[9:8]);
      va = {{32{lfsr[13]}}, 28'd0, lfsr[13:10]};
      vb = {{32{lfsr[17]}}, 28'd0, lfsr[17:14]};
      doCmp(t, r, f, va, vb, {lfsr[19], 3'd0, lfsr[13:10]}, int'(lfsr[22:20]),
            int'(lfsr[25:23]), int'(lfsr[28:26]), int'(lfsr[31:29]),
            "R1 R3 R4 R5 R6 R8 R9 random");
    end
    for (int i = 0; i < 8; i++) readP(i, "R10 R12 random final");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule